// File: doc/BRIEF.md
# USB Endpoint Buffer-Descriptor Address Generator

This block turns an endpoint number and a transfer direction into the byte address of the buffer descriptor that the USB engine must use next. The descriptor table starts at byte 0x400. Each descriptor takes four bytes. A two-bit buffering mode picks one of four layouts. The layouts differ in which endpoint directions get a pair of descriptors (an even one and an odd one) instead of a single descriptor.

The block keeps one ping-pong pointer for each endpoint direction. When the engine finishes a transaction and releases a descriptor, it pulses a completion strobe. If the selected direction is ping-ponged, that direction's pointer flips, so the next access goes to the other descriptor of the pair. The block also reports whether the last accepted transaction used an even or an odd descriptor. It reports how many descriptors the current layout occupies.

The pointers return to even in three cases: when the block is disabled, when a global clear is requested, and when the mode changes while the block is enabled.

Top module: `usb_bd_addr_gen`

## Requirements
- R1: In mode 0 (no pairs), the descriptor index is 2*ep + dir, where dir is 0 for OUT and 1 for IN. The address is 0x400 + 4*index.
- R2: In mode 1, only endpoint 0 OUT is paired. Endpoint 0 OUT uses index 0 when its pointer is even and index 1 when it is odd. Endpoint 0 IN uses index 2. Any endpoint ep of 1 or more uses index 2*ep + dir + 1.
- R3: In mode 2, every direction is paired. The index is 4*ep + 2*dir + p, where p is that direction's pointer (0 is even, 1 is odd).
- R4: In mode 3, every direction except those of endpoint 0 is paired. Endpoint 0 OUT uses index 0 and endpoint 0 IN uses index 1. Any endpoint ep of 1 or more uses index 4*ep - 2 + 2*dir + p.
- R5: The descriptor count output is 32, 33, 64 and 62 for modes 0, 1, 2 and 3.
- R6: An accepted completion flips the pointer of the selected endpoint direction only if that direction is paired in the current mode. All other pointers keep their values, and unpaired directions stay even.
- R7: After an accepted completion, the parity output gives the pointer value that the released descriptor used: 1 for odd, and 0 for an unpaired direction. The parity output keeps its value in every enabled cycle with no accepted completion.
- R8: A pointer-clear request sets every pointer to even on the next clock. A completion in the same cycle is dropped, and neither the pointers nor the parity output take it into account.
- R9: A mode value that differs from the one seen in the previous cycle, while the block is enabled, sets every pointer to even. A completion in that cycle is dropped.
- R10: While the enable is low, all pointers and the parity output are held at 0, and completions have no effect.
- R11: After reset, every pointer is even and the parity output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Module enable; low holds every pointer at even |
| buf_mode | input | 2 | Buffering layout select (0 to 3) |
| ep_num | input | 4 | Endpoint number of the current access |
| ep_dir | input | 1 | Direction of the current access: 0 is OUT, 1 is IN |
| xfer_done | input | 1 | Completion strobe for the current endpoint direction |
| ptr_clear | input | 1 | Request to set every pointer to even |
| bd_addr | output | 12 | Byte address of the descriptor for the current access |
| last_odd | output | 1 | Parity of the last accepted completion |
| bd_count | output | 7 | Number of descriptors in the current layout |

## Verification
Each mode is first swept over all 32 endpoint directions with the pointers even. This shows whether the base layouts and the counts are correct before any pointer moves. Completions are then applied repeatedly to one paired direction and to one unpaired direction, interleaved with accesses to their neighbours. This tells a shared or wrongly indexed pointer apart from a correct per-direction toggle. It also catches an unpaired direction that wrongly toggles. Clear requests and mode changes are made to coincide with completions, which exposes a wrong precedence. A long pseudo-random stretch mixes all inputs, including enable drops, against a behavioural model that derives each index by counting slots through the table.

// File: rtl/usb_bd_pkg.sv
package usb_bd_pkg;

  typedef enum logic [1:0] {
    LAYOUT_SINGLE   = 2'd0,
    LAYOUT_EP0_OUT  = 2'd1,
    LAYOUT_ALL_PAIR = 2'd2,
    LAYOUT_NOT_EP0  = 2'd3
  } bd_layout_e;

  // Whether endpoint ep, direction dir holds an even/odd pair in this layout.
  function automatic logic pair_active(input bd_layout_e mode, input int ep, input logic dir);
    case (mode)
      LAYOUT_SINGLE:   pair_active = 1'b0;
      LAYOUT_EP0_OUT:  pair_active = (ep == 0) && (dir == 1'b0);
      LAYOUT_ALL_PAIR: pair_active = 1'b1;
      default:         pair_active = (ep != 0);
    endcase
  endfunction

  // Table slot index for an access.
  function automatic int slot_index(input bd_layout_e mode, input int ep, input logic dir,
                                    input logic pp);
    int d;
    int p;
    d = dir ? 1 : 0;
    p = pp ? 1 : 0;
    case (mode)
      LAYOUT_SINGLE:   slot_index = 2 * ep + d;
      LAYOUT_EP0_OUT:  slot_index = (ep == 0) ? ((d == 0) ? p : 2) : (2 * ep + d + 1);
      LAYOUT_ALL_PAIR: slot_index = 4 * ep + 2 * d + p;
      default:         slot_index = (ep == 0) ? d : (4 * ep - 2 + 2 * d + p);
    endcase
  endfunction

  // Descriptors occupied by a layout for num_ep endpoints.
  function automatic int slot_total(input bd_layout_e mode, input int num_ep);
    case (mode)
      LAYOUT_SINGLE:   slot_total = 2 * num_ep;
      LAYOUT_EP0_OUT:  slot_total = 2 * num_ep + 1;
      LAYOUT_ALL_PAIR: slot_total = 4 * num_ep;
      default:         slot_total = 4 * num_ep - 2;
    endcase
  endfunction

endpackage

// File: rtl/ppb_ptr_bank.sv
module ppb_ptr_bank #(
  parameter int NUM_EP = 16,
  localparam int SLOTS = 2 * NUM_EP,
  localparam int SEL_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             flip_en,
  input  logic [SEL_W-1:0] flip_sel,
  output logic [SLOTS-1:0] ptr_vec
);

  for (genvar g = 0; g < SLOTS; g++) begin : g_ptr
    logic hit;
    assign hit = flip_en && (flip_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr_vec[g] <= 1'b0;
      else if (clr) ptr_vec[g] <= 1'b0;
      else if (hit) ptr_vec[g] <= ~ptr_vec[g];
    end
  end

endmodule

// File: rtl/ppb_ctrl.sv
module ppb_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] buf_mode,
  input  logic       xfer_done,
  input  logic       ptr_clear,
  input  logic       pp_on,
  input  logic       cur_pp,
  output logic       clr_evt,
  output logic       acc_evt,
  output logic       flip_evt,
  output logic       last_odd
);

  logic [1:0] mode_q;
  logic       mode_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 2'd0;
    else        mode_q <= buf_mode;
  end

  assign mode_chg = (buf_mode != mode_q);
  // Clearing takes precedence over any completion in the same cycle.
  assign clr_evt  = !enable || ptr_clear || mode_chg;
  assign acc_evt  = xfer_done && !clr_evt;
  assign flip_evt = acc_evt && pp_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_odd <= 1'b0;
    else if (!enable) last_odd <= 1'b0;
    else if (acc_evt) last_odd <= pp_on && cur_pp;
  end

endmodule

// File: rtl/bd_index_map.sv
module bd_index_map
  import usb_bd_pkg::*;
#(
  parameter int          NUM_EP   = 16,
  parameter int          ADDR_W   = 12,
  parameter int          BD_BASE  = 'h400,
  parameter int          BD_BYTES = 4,
  localparam int         EP_W     = $clog2(NUM_EP),
  localparam int         SLOTS    = 2 * NUM_EP,
  localparam int         SEL_W    = $clog2(SLOTS),
  localparam int         CNT_W    = $clog2(4 * NUM_EP + 1)
) (
  input  logic [1:0]       buf_mode,
  input  logic [EP_W-1:0]  ep_num,
  input  logic             ep_dir,
  input  logic [SLOTS-1:0] ptr_vec,
  output logic [SEL_W-1:0] sel,
  output logic             pp_on,
  output logic             cur_pp,
  output logic [ADDR_W-1:0] bd_addr,
  output logic [CNT_W-1:0] bd_count
);

  bd_layout_e mode;
  int         ep_i;
  int         idx;

  assign mode  = bd_layout_e'(buf_mode);
  assign ep_i  = int'(ep_num);
  assign sel   = {ep_num, ep_dir};
  assign pp_on = pair_active(mode, ep_i, ep_dir);
  // An unpaired direction always addresses with an even pointer.
  assign cur_pp = pp_on && ptr_vec[sel];

  always_comb begin
    idx      = slot_index(mode, ep_i, ep_dir, cur_pp);
    bd_addr  = ADDR_W'(BD_BASE + BD_BYTES * idx);
    bd_count = CNT_W'(slot_total(mode, NUM_EP));
  end

endmodule

// File: rtl/usb_bd_addr_gen.sv
module usb_bd_addr_gen #(
  parameter int  NUM_EP   = 16,
  parameter int  ADDR_W   = 12,
  parameter int  BD_BASE  = 'h400,
  parameter int  BD_BYTES = 4,
  localparam int EP_W     = $clog2(NUM_EP),
  localparam int SLOTS    = 2 * NUM_EP,
  localparam int SEL_W    = $clog2(SLOTS),
  localparam int CNT_W    = $clog2(4 * NUM_EP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        buf_mode,
  input  logic [EP_W-1:0]   ep_num,
  input  logic              ep_dir,
  input  logic              xfer_done,
  input  logic              ptr_clear,
  output logic [ADDR_W-1:0] bd_addr,
  output logic              last_odd,
  output logic [CNT_W-1:0]  bd_count
);

  logic [SLOTS-1:0] ptr_vec;
  logic [SEL_W-1:0] sel;
  logic             pp_on;
  logic             cur_pp;
  logic             clr_evt;
  logic             acc_evt;
  logic             flip_evt;

  bd_index_map #(
    .NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .BD_BASE(BD_BASE), .BD_BYTES(BD_BYTES)
  ) u_map (
    .buf_mode(buf_mode), .ep_num(ep_num), .ep_dir(ep_dir), .ptr_vec(ptr_vec),
    .sel(sel), .pp_on(pp_on), .cur_pp(cur_pp), .bd_addr(bd_addr), .bd_count(bd_count)
  );

  ppb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .buf_mode(buf_mode),
    .xfer_done(xfer_done), .ptr_clear(ptr_clear), .pp_on(pp_on), .cur_pp(cur_pp),
    .clr_evt(clr_evt), .acc_evt(acc_evt), .flip_evt(flip_evt), .last_odd(last_odd)
  );

  ppb_ptr_bank #(.NUM_EP(NUM_EP)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr_evt), .flip_en(flip_evt),
    .flip_sel(sel), .ptr_vec(ptr_vec)
  );

endmodule

// File: rtl/usb_bd_addr_gen_chk.sv
module usb_bd_addr_gen_chk #(
  parameter int  NUM_EP   = 16,
  parameter int  ADDR_W   = 12,
  parameter int  BD_BASE  = 'h400,
  parameter int  BD_BYTES = 4,
  localparam int SLOTS    = 2 * NUM_EP,
  localparam int SEL_W    = $clog2(SLOTS),
  localparam int CNT_W    = $clog2(4 * NUM_EP + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              xfer_done,
  input logic [ADDR_W-1:0] bd_addr,
  input logic              last_odd,
  input logic [CNT_W-1:0]  bd_count,
  input logic [SLOTS-1:0]  ptr_vec,
  input logic [SEL_W-1:0]  sel,
  input logic              pp_on,
  input logic              cur_pp,
  input logic              clr_evt,
  input logic              acc_evt
);

  // R1 R2 R3 R4 R5: every address lies inside the table the count describes
  assert_addr_in_table_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bd_addr) >= BD_BASE) &&
    (int'(bd_addr) < BD_BASE + BD_BYTES * int'(bd_count)));

  assert_clear_evens_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (ptr_vec == '0));

  assert_disabled_parity_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !last_odd);

  assert_paired_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && pp_on) |=> (ptr_vec[$past(sel)] != $past(ptr_vec[sel])));

  assert_unpaired_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && !pp_on) |=> $stable(ptr_vec));

  assert_parity_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> (last_odd == $past(cur_pp)));

  assert_parity_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !xfer_done) |=> $stable(last_odd));

endmodule

bind usb_bd_addr_gen usb_bd_addr_gen_chk #(
  .NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .BD_BASE(BD_BASE), .BD_BYTES(BD_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .xfer_done(xfer_done),
  .bd_addr(bd_addr), .last_odd(last_odd), .bd_count(bd_count), .ptr_vec(ptr_vec),
  .sel(sel), .pp_on(pp_on), .cur_pp(cur_pp), .clr_evt(clr_evt), .acc_evt(acc_evt)
);

// File: tb/usb_bd_addr_gen_tb.sv
module usb_bd_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  buf_mode = 2'd0;
  logic [3:0]  ep_num = 4'd0;
  logic        ep_dir = 1'b0;
  logic        xfer_done = 1'b0;
  logic        ptr_clear = 1'b0;
  logic [11:0] bd_addr;
  logic        last_odd;
  logic [6:0]  bd_count;

  int    n_vec = 0;
  int    n_bad = 0;
  int    cycles = 0;
  bit    done_flag = 0;
  string tag = "R11";

  // Behavioural model state
  int m_ptr [16][2];
  int m_last = 0;
  int m_prev_mode = 0;

  always #10 clk = ~clk;

  usb_bd_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .buf_mode(buf_mode),
    .ep_num(ep_num), .ep_dir(ep_dir), .xfer_done(xfer_done), .ptr_clear(ptr_clear),
    .bd_addr(bd_addr), .last_odd(last_odd), .bd_count(bd_count)
  );

  function automatic bit ref_paired(int mode, int e, int d);
    if (mode == 0) return 0;
    if (mode == 1) return (e == 0 && d == 0);
    if (mode == 2) return 1;
    return (e != 0);
  endfunction

  // Walk the table in layout order, counting slots, until the target is reached.
  function automatic int ref_slot(int mode, int e_t, int d_t, int p);
    int n = 0;
    for (int e = 0; e < 16; e++)
      for (int d = 0; d < 2; d++) begin
        if (e == e_t && d == d_t)
          return ref_paired(mode, e, d) ? n + p : n;
        n += ref_paired(mode, e, d) ? 2 : 1;
      end
    return n;
  endfunction

  function automatic int ref_total(int mode);
    return ref_slot(mode, 99, 0, 0);
  endfunction

  task automatic model_clear();
    for (int e = 0; e < 16; e++)
      for (int d = 0; d < 2; d++) m_ptr[e][d] = 0;
  endtask

  task automatic compare();
    int mode = int'(buf_mode);
    int e = int'(ep_num);
    int d = int'(ep_dir);
    int p = ref_paired(mode, e, d) ? m_ptr[e][d] : 0;
    int exp_addr = 'h400 + 4 * ref_slot(mode, e, d, p);
    n_vec++;
    if (int'(bd_addr) != exp_addr) begin
      n_bad++;
      $display("FAIL %s addr mode=%0d ep=%0d dir=%0d got %h exp %h", tag, mode, e, d, bd_addr, exp_addr);
    end
    n_vec++;
    if (int'(last_odd) != m_last) begin
      n_bad++;
      $display("FAIL %s last_odd got %0d exp %0d", tag, last_odd, m_last);
    end
    n_vec++;
    if (int'(bd_count) != ref_total(mode)) begin
      n_bad++;
      $display("FAIL R5 count mode=%0d got %0d exp %0d", mode, bd_count, ref_total(mode));
    end
  endtask

  task automatic model_edge();
    int mode = int'(buf_mode);
    int e = int'(ep_num);
    int d = int'(ep_dir);
    if (!enable) begin
      model_clear();
      m_last = 0;
    end else if (ptr_clear || mode != m_prev_mode) begin
      model_clear();
    end else if (xfer_done) begin
      if (ref_paired(mode, e, d)) begin
        m_last = m_ptr[e][d];
        m_ptr[e][d] = 1 - m_ptr[e][d];
      end else begin
        m_last = 0;
      end
    end
    m_prev_mode = mode;
  endtask

  // One cycle: inputs driven at the falling edge, checked before the rising edge.
  task automatic step(bit en, int mode, int e, int d, bit dn, bit clr);
    enable = en; buf_mode = 2'(mode); ep_num = 4'(e); ep_dir = 1'(d);
    xfer_done = dn; ptr_clear = clr;
    #5;
    compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    tag = "R11";
    step(1, 0, 0, 0, 0, 0);

    // R1: single layout sweep
    tag = "R1";
    for (int e = 0; e < 16; e++) for (int d = 0; d < 2; d++) step(1, 0, e, d, 0, 0);
    // R2: EP0 OUT paired only
    tag = "R2";
    step(1, 1, 0, 0, 0, 0);
    for (int e = 0; e < 16; e++) for (int d = 0; d < 2; d++) step(1, 1, e, d, 0, 0);
    step(1, 1, 0, 0, 1, 0); step(1, 1, 0, 0, 0, 0); step(1, 1, 0, 1, 0, 0);
    // R3: all paired
    tag = "R3";
    step(1, 2, 0, 0, 0, 0);
    for (int e = 0; e < 16; e++) for (int d = 0; d < 2; d++) step(1, 2, e, d, 0, 0);
    // R6: toggles on one direction, neighbours untouched
    tag = "R6";
    for (int k = 0; k < 3; k++) begin
      step(1, 2, 5, 1, 1, 0); step(1, 2, 5, 1, 0, 0);
      step(1, 2, 5, 0, 0, 0); step(1, 2, 6, 1, 0, 0);
    end
    // R4: all paired except EP0
    tag = "R4";
    step(1, 3, 0, 0, 0, 0);
    for (int e = 0; e < 16; e++) for (int d = 0; d < 2; d++) step(1, 3, e, d, 0, 0);
    tag = "R7";
    step(1, 3, 7, 0, 1, 0); step(1, 3, 7, 0, 0, 0);
    step(1, 3, 7, 0, 1, 0); step(1, 3, 7, 0, 0, 0);
    step(1, 3, 9, 1, 1, 0); step(1, 3, 0, 1, 1, 0); step(1, 3, 0, 1, 0, 0);
    // R8: clear beats completion
    tag = "R8";
    step(1, 3, 9, 1, 0, 0);
    step(1, 3, 9, 1, 1, 1); step(1, 3, 9, 1, 0, 0); step(1, 3, 9, 0, 0, 0);
    // R9: mode change clears, drops completion
    tag = "R9";
    step(1, 2, 3, 0, 1, 0); step(1, 2, 3, 0, 0, 0);
    step(1, 3, 3, 0, 1, 0); step(1, 3, 3, 0, 0, 0);
    // R10: disabled holds even, ignores completions
    tag = "R10";
    step(1, 3, 4, 1, 1, 0); step(0, 3, 4, 1, 1, 0);
    step(0, 3, 4, 1, 1, 0); step(1, 3, 4, 1, 0, 0);

    // Mixed pseudo-random traffic
    tag = "R6";
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[15:12] != 4'd0, (lfsr[11:8] == 4'd0) ? int'(lfsr[1:0]) : int'(buf_mode),
           int'(lfsr[7:4]), int'(lfsr[3]), lfsr[2] | lfsr[9], lfsr[11:8] == 4'd15);
    end
    finish_run();
  end

endmodule